// File: doc/BRIEF.md
# Stream Byte and Frame Statistics Tap

This block sits beside a stream interface and observes it without driving any of its signals. A beat is seen only when valid and ready are both high in the same cycle. On such a beat, the block adds the number of active byte lanes to a running byte total. It also adds one to a running frame total when the beat closes a frame. Both totals saturate at their all-ones value instead of wrapping.

A single-cycle trigger pulse takes a snapshot of both totals together with a tag supplied on an input. The same edge restarts both totals. The snapshot then leaves on a byte-wide output stream with valid/ready flow control, as one short frame. That frame can be merged with snapshot frames from other taps further down the chain. A trigger that arrives while a snapshot is still being sent is dropped.

The sender is a two-state machine. `SER_IDLE` waits for an accepted trigger; the transition *load* moves it to `SER_SEND`. In `SER_SEND` the transition *advance* shifts out the next byte on each accepted output beat. The transition *finish* returns to `SER_IDLE` when the final byte is accepted.

Top module: `stream_stat_tap`

## Requirements
- R1: On each cycle with `mon_valid` and `mon_ready` both high, the byte total grows by the number of set bits in `mon_keep`; cycles without that handshake leave it unchanged.
- R2: The frame total grows by one on each handshake cycle with `mon_last` high, and on no other cycle.
- R3: During and right after reset, `out_valid`, `out_last` and `busy` are low and both totals are zero.
- R4: A `trig` pulse while `busy` is low captures `tag_in` and both totals as they stood before that cycle and clears the totals. `out_valid` and `busy` rise on the next cycle.
- R5: A monitored handshake in the same cycle as an accepted trigger is counted in the new interval, not in the snapshot.
- R6: The snapshot frame has (TAG_W+BCNT_W+FCNT_W)/8 bytes, 10 at default widths, sent most significant byte first. The tag comes first, then the byte total, then the frame total. `out_last` is high only on the final byte.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R8: `busy` stays high from the cycle after an accepted trigger until the cycle after the final byte is accepted. A `trig` while `busy` is high changes neither the snapshot nor the totals.
- R9: A total that would pass its all-ones value stays at all-ones until the next accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_keep | input | KEEP_W | Byte-lane enables of the observed stream |
| mon_valid | input | 1 | Valid of the observed stream |
| mon_ready | input | 1 | Ready of the observed stream |
| mon_last | input | 1 | End-of-frame flag of the observed stream |
| trig | input | 1 | Snapshot-and-clear request, one cycle |
| tag_in | input | TAG_W | Tag placed at the head of the snapshot |
| out_data | output | 8 | Snapshot byte |
| out_valid | output | 1 | Snapshot byte valid |
| out_ready | input | 1 | Downstream ready for the snapshot byte |
| out_last | output | 1 | Final byte of the snapshot frame |
| busy | output | 1 | Snapshot transmission in progress |

## Verification
Every output comes straight from a register, so each result shows up exactly one cycle after the edge that causes it. The first snapshot byte appears one cycle after an accepted trigger. Each later byte appears one cycle after an accepted output beat. `busy` falls one cycle after the final byte is accepted. The bench updates a behavioural model on the same rising edge as the design and compares all outputs on the following falling edge, every cycle. A one-cycle slip on any of these paths therefore shows up as a mismatch.

// File: rtl/stat_tap_pkg.sv
package stat_tap_pkg;
    typedef enum logic [0:0] {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;
endpackage

// File: rtl/stat_keep_count.sv
module stat_keep_count #(
    parameter int KEEP_W = 4,
    localparam int CNT_W = $clog2(KEEP_W + 1)
) (
    input  logic [KEEP_W-1:0] keep,
    input  logic              take,
    output logic [CNT_W-1:0]  ones
);
    always_comb begin
        ones = '0;
        if (take) begin
            for (int i = 0; i < KEEP_W; i++) begin
                ones = ones + CNT_W'(keep[i]);
            end
        end
    end
endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);
    logic [W-1:0] base;
    logic [W:0]   sum;

    // The clear and the increment of one cycle combine: new interval starts at inc.
    always_comb begin
        base = clr ? '0 : cnt;
        sum  = {1'b0, base} + {{(W + 1 - INC_W){1'b0}}, inc};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sum[W]) begin
            cnt <= '1;
        end else begin
            cnt <= sum[W-1:0];
        end
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == '1) |=> (cnt == '1));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc == '0) |=> $stable(cnt));
endmodule

// File: rtl/stat_snap_serializer.sv
module stat_snap_serializer
    import stat_tap_pkg::*;
#(
    parameter int FRAME_W = 80,
    localparam int NBYTES = FRAME_W / 8,
    localparam int IDX_W  = $clog2(NBYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    output logic [7:0]         out_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_last,
    output logic               busy
);
    ser_state_e         state;
    ser_state_e         state_nx;
    logic [FRAME_W-1:0] sreg;
    logic [IDX_W-1:0]   idx;
    logic               at_end;
    logic               beat;

    assign at_end = (idx == IDX_W'(NBYTES - 1));
    assign beat   = (state == SER_SEND) && out_ready;

    // Next-state selection: load, advance, finish.
    always_comb begin
        state_nx = state;
        unique case (state)
            SER_IDLE: if (load)          state_nx = SER_SEND;
            SER_SEND: if (beat && at_end) state_nx = SER_IDLE;
            default:                     state_nx = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SER_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
        end else begin
            unique case (state)
                SER_IDLE: begin
                    if (load) begin
                        sreg <= word;
                        idx  <= '0;
                    end
                end
                SER_SEND: begin
                    if (beat) begin
                        sreg <= {sreg[FRAME_W-9:0], 8'h00};
                        idx  <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        out_valid = (state == SER_SEND);
        busy      = (state == SER_SEND);
        out_last  = (state == SER_SEND) && at_end;
        out_data  = sreg[FRAME_W-1 -: 8];
    end

    // R7
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8
    finish_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !busy);

    // R6
    first_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !out_last);

    // R8
    send_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(out_ready && out_last)) |=> busy);
endmodule

// File: rtl/stream_stat_tap.sv
module stream_stat_tap #(
    parameter int DATA_W = 32,
    parameter int KEEP_W = DATA_W / 8,
    parameter int TAG_W  = 16,
    parameter int BCNT_W = 32,
    parameter int FCNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEEP_W-1:0] mon_keep,
    input  logic              mon_valid,
    input  logic              mon_ready,
    input  logic              mon_last,
    input  logic              trig,
    input  logic [TAG_W-1:0]  tag_in,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last,
    output logic              busy
);
    localparam int FRAME_W = TAG_W + BCNT_W + FCNT_W;
    localparam int KC_W    = $clog2(KEEP_W + 1);

    logic              hs;
    logic              fire;
    logic [KC_W-1:0]   lane_ones;
    logic [BCNT_W-1:0] byte_tot;
    logic [FCNT_W-1:0] frame_tot;

    assign hs   = mon_valid && mon_ready;
    assign fire = trig && !busy;

    stat_keep_count #(.KEEP_W(KEEP_W)) u_keep (
        .keep (mon_keep),
        .take (hs),
        .ones (lane_ones)
    );

    stat_sat_counter #(.W(BCNT_W), .INC_W(KC_W)) u_bytes (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fire),
        .inc   (lane_ones),
        .cnt   (byte_tot)
    );

    stat_sat_counter #(.W(FCNT_W), .INC_W(1)) u_frames (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fire),
        .inc   (hs && mon_last),
        .cnt   (frame_tot)
    );

    stat_snap_serializer #(.FRAME_W(FRAME_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire),
        .word      ({tag_in, byte_tot, frame_tot}),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .busy      (busy)
    );

    // R6
    initial begin
        field_width_chk: assert ((TAG_W % 8 == 0) && (BCNT_W % 8 == 0) && (FCNT_W % 8 == 0)
                                 && FRAME_W >= 16 && BCNT_W >= KC_W);
    end

    // R4
    fire_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (busy && out_valid));

    // R2
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && hs && mon_last && frame_tot != '1) |=> (frame_tot == $past(frame_tot) + 1'b1));

    // R5
    fire_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !(hs && mon_last)) |=> (frame_tot == '0));
endmodule

// File: tb/stream_stat_tap_bench.sv
module stream_stat_tap_bench;
    localparam int DW = 32;
    localparam int KW = DW / 8;
    localparam int TW = 16;
    localparam int BW = 16;
    localparam int FW = 16;
    localparam int NB = (TW + BW + FW) / 8;
    localparam int BMAX = (1 << BW) - 1;
    localparam int FMAX = (1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [KW-1:0] mon_keep = '0;
    logic          mon_valid = 1'b0;
    logic          mon_ready = 1'b0;
    logic          mon_last = 1'b0;
    logic          trig = 1'b0;
    logic [TW-1:0] tag_in = '0;
    logic [7:0]    out_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          out_last;
    logic          busy;

    stream_stat_tap #(.DATA_W(DW), .TAG_W(TW), .BCNT_W(BW), .FCNT_W(FW)) u_stream_stat_tap (
        .clk(clk), .rst_n(rst_n), .mon_keep(mon_keep), .mon_valid(mon_valid),
        .mon_ready(mon_ready), .mon_last(mon_last), .trig(trig), .tag_in(tag_in),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last), .busy(busy)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc_n = 0;
    string cur_req = "R3";

    int        m_bc = 0;
    int        m_fc = 0;
    bit        m_busy = 0;
    bit [7:0]  m_q[$];

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc_n);
        end
    endtask

    // Reference model, advanced on the same edge as the design.
    always @(posedge clk) begin
        cyc_n++;
        if (!rst_n) begin
            m_bc = 0; m_fc = 0; m_busy = 0; m_q.delete();
        end else begin
            int  add;
            bit  fadd;
            bit  fire;
            logic [TW+BW+FW-1:0] w;
            add = 0;
            fadd = mon_valid && mon_ready && mon_last;
            if (mon_valid && mon_ready)
                for (int i = 0; i < KW; i++) add += mon_keep[i];
            fire = trig && !m_busy;
            if (m_busy && out_ready) begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) m_busy = 0;
            end
            if (fire) begin
                w = {tag_in, m_bc[BW-1:0], m_fc[FW-1:0]};
                for (int i = NB - 1; i >= 0; i--) m_q.push_back(w[i*8 +: 8]);
                m_busy = 1;
                m_bc = 0;
                m_fc = 0;
            end
            m_bc = (m_bc + add > BMAX) ? BMAX : m_bc + add;
            m_fc = (m_fc + int'(fadd) > FMAX) ? FMAX : m_fc + int'(fadd);
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8", {cur_req, " busy"}, busy, m_busy);
            check("R4", {cur_req, " out_valid"}, out_valid, m_busy);
            if (m_busy) begin
                check("R6", {cur_req, " out_data"}, out_data, m_q[0]);
                check("R6", {cur_req, " out_last"}, out_last, m_q.size() == 1);
            end else begin
                check("R6", {cur_req, " out_last idle"}, out_last, 0);
            end
        end
    end

    task automatic step(bit v, bit r, logic [KW-1:0] k, bit l, bit t);
        mon_valid = v; mon_ready = r; mon_keep = k; mon_last = l; trig = t;
        @(negedge clk);
        mon_valid = 0; mon_ready = 0; trig = 0; mon_last = 0;
    endtask

    task automatic drain();
        out_ready = 1;
        for (int i = 0; i < 40 && m_busy; i++) @(negedge clk);
        @(negedge clk);
        out_ready = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3", "out_valid in reset", out_valid, 0);
        check("R3", "busy in reset", busy, 0);
        check("R3", "out_last in reset", out_last, 0);
        rst_n = 1;
        @(negedge clk);
        check("R3", "out_valid after reset", out_valid, 0);

        // R3: first snapshot right after reset shows zero totals
        cur_req = "R3";
        tag_in = 16'hA55A;
        step(0, 0, '0, 0, 1);
        drain();

        // R1: byte lanes on handshake beats only
        cur_req = "R1";
        step(1, 1, 4'b1111, 0, 0);
        step(1, 1, 4'b0011, 0, 0);
        step(1, 0, 4'b1111, 0, 0);
        step(0, 1, 4'b1111, 0, 0);
        step(1, 1, 4'b1000, 0, 0);
        step(1, 1, 4'b0000, 0, 0);
        tag_in = 16'h1234;
        step(0, 0, '0, 0, 1);
        drain();

        // R2: frame ends on handshake beats only
        cur_req = "R2";
        step(1, 1, 4'b0001, 1, 0);
        step(1, 0, 4'b0001, 1, 0);
        step(1, 1, 4'b0111, 0, 0);
        step(1, 1, 4'b0111, 1, 0);
        step(0, 1, 4'b0111, 1, 0);
        tag_in = 16'hBEEF;
        step(0, 0, '0, 0, 1);
        drain();

        // R5: beat in the trigger cycle belongs to the new interval
        cur_req = "R5";
        step(1, 1, 4'b1111, 1, 0);
        step(1, 1, 4'b0110, 1, 1);
        drain();
        step(0, 0, '0, 0, 1);
        drain();

        // R7: stalled output holds, random ready pattern
        cur_req = "R7";
        for (int i = 0; i < 7; i++) step(1, 1, 4'(i), i[0], 0);
        tag_in = 16'h0F0F;
        step(0, 0, '0, 0, 1);
        for (int i = 0; i < 60; i++) begin
            out_ready = $urandom_range(0, 2) == 0;
            @(negedge clk);
        end
        drain();

        // R8: triggers while busy are dropped, counting continues
        cur_req = "R8";
        step(1, 1, 4'b1111, 1, 0);
        tag_in = 16'h7777;
        step(0, 0, '0, 0, 1);
        tag_in = 16'h9999;
        step(1, 1, 4'b0011, 1, 1);
        step(0, 0, '0, 0, 1);
        out_ready = 1;
        for (int i = 0; i < NB; i++) begin
            mon_valid = 1; mon_ready = 1; mon_keep = 4'b0001; trig = 1;
            @(negedge clk);
        end
        mon_valid = 0; mon_ready = 0; trig = 0;
        out_ready = 0;
        drain();
        step(0, 0, '0, 0, 1);
        drain();

        // R9: both totals saturate
        cur_req = "R9";
        mon_valid = 1; mon_ready = 1; mon_keep = 4'b1111; mon_last = 1;
        repeat (16400) @(negedge clk);
        mon_keep = 4'b0000;
        repeat (49200) @(negedge clk);
        mon_valid = 0; mon_ready = 0; mon_last = 0;
        check("R9", "model byte total saturated", m_bc, BMAX);
        check("R9", "model frame total saturated", m_fc, FMAX);
        tag_in = 16'hC0DE;
        step(0, 0, '0, 0, 1);
        drain();
        step(0, 0, '0, 0, 1);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule